// File: doc/BRIEF.md
# Odd-Amount Select Rotator

This block rotates an 8-bit word to the left by an odd number of positions, chosen from 1, 3, 5 or 7 by a 3-bit select. It is purely combinational: each output bit comes from its own 8-to-1 multiplexer, and all multiplexers share one decoded control word. Bits that leave the top of the word come back in at the bottom, so no data is lost while a rotation is enabled.

The lowest select bit enables the block. The upper two select bits choose the amount, which is twice their value plus one. When the enable bit is low, the output is held at all zeros rather than passing the input through. A datapath uses this to gate a rotated operand into a following stage in the same cycle.

Top module: `oddsel_rotator`

## Requirements
- R1: With select 3'b001, the output is the input rotated left by one position (11010000 gives 10100001).
- R2: With select 3'b011, the output is the input rotated left by three positions (11010000 gives 10000110).
- R3: With select 3'b101, the output is the input rotated left by five positions (11010000 gives 00011010).
- R4: With select 3'b111, the output is the input rotated left by seven positions (11010000 gives 01101000).
- R5: Whenever select bit 0 is 0 (selects 000, 010, 100 and 110), the output is 8'h00 for every input value.
- R6: While select bit 0 is 1, the output has exactly as many 1 bits as the input, because bit 7 wraps into bit 0.
- R7: The output follows a change on either input with no clock edge involved; the block holds no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 8 | Word to rotate |
| sel | input | 3 | Bit 0 enables the rotation; bits 2:1 pick the amount as 2*sel[2:1]+1 |
| dout | output | 8 | Rotated word, or zero when the rotation is disabled |

## Verification
The bench builds the block at its default width of 8 bits and a 3-bit select. At that size all 2048 combinations of input word and select can be tried, so every multiplexer leg and every disabled code is covered, not a sample of them. The worked example word 11010000 is checked against each odd amount. Inputs are also changed between clock edges to show that the output does not wait for an edge.

// File: rtl/oddsel_pkg.sv
package oddsel_pkg;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned SEL_W  = $clog2(DATA_W);
    localparam int unsigned AMT_W  = SEL_W;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [SEL_W-1:0]  sel_t;

    typedef struct packed {
        logic             en;
        logic [AMT_W-1:0] amt;
    } rot_ctl_t;

    // bit 0 enables; upper bits give the odd amount 2*hi+1
    function automatic rot_ctl_t to_ctl(input sel_t s);
        rot_ctl_t c;
        c.en  = s[0];
        c.amt = {s[SEL_W-1:1], 1'b1};
        return c;
    endfunction
endpackage

// File: rtl/oddsel_decode.sv
module oddsel_decode
    import oddsel_pkg::*;
(
    input  sel_t     sel,
    output rot_ctl_t ctl
);
    always_comb begin
        ctl = to_ctl(sel);
    end
endmodule

// File: rtl/oddsel_bitmux.sv
module oddsel_bitmux
    import oddsel_pkg::*;
#(
    parameter int unsigned BIT_IDX = 0
) (
    input  word_t    din,
    input  rot_ctl_t ctl,
    output logic     q
);
    // leg k carries the source bit for a left rotation by k
    logic [DATA_W-1:0] leg;

    for (genvar k = 0; k < DATA_W; k++) begin : g_leg
        assign leg[k] = din[(BIT_IDX + DATA_W - k) % DATA_W];
    end

    always_comb begin
        q = ctl.en ? leg[ctl.amt] : 1'b0;
    end
endmodule

// File: rtl/oddsel_rot_net.sv
module oddsel_rot_net
    import oddsel_pkg::*;
(
    input  word_t    din,
    input  rot_ctl_t ctl,
    output word_t    dout
);
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        oddsel_bitmux #(.BIT_IDX(b)) mux_i (
            .din (din),
            .ctl (ctl),
            .q   (dout[b])
        );
    end
endmodule

// File: rtl/oddsel_rotator.sv
module oddsel_rotator
    import oddsel_pkg::*;
(
    input  logic [DATA_W-1:0] din,
    input  logic [SEL_W-1:0]  sel,
    output logic [DATA_W-1:0] dout
);
    rot_ctl_t ctl;

    oddsel_decode dec_i (
        .sel (sel),
        .ctl (ctl)
    );

    oddsel_rot_net net_i (
        .din  (din),
        .ctl  (ctl),
        .dout (dout)
    );
endmodule

// File: rtl/oddsel_rotator_chk.sv
module oddsel_rotator_chk
    import oddsel_pkg::*;
(
    input logic [DATA_W-1:0] din,
    input logic [SEL_W-1:0]  sel,
    input logic [DATA_W-1:0] dout
);
    always_comb begin
        // R5: disabled select yields zero
        if (!sel[0]) a_r5_off_zero: assert (dout == '0);
        // R6: enabled rotation keeps the population count
        if (sel[0]) a_r6_ones_kept: assert ($countones(dout) == $countones(din));
        // R1: smallest amount moves the top bit to bit 0
        if (sel == sel_t'(1)) a_r1_rot_one: assert (dout == {din[DATA_W-2:0], din[DATA_W-1]});
        // R4: largest amount moves bit 0 to the top
        if (sel == '1) a_r4_rot_max: assert (dout == {din[0], din[DATA_W-1:1]});
    end
endmodule

bind oddsel_rotator oddsel_rotator_chk chk_i (
    .din  (din),
    .sel  (sel),
    .dout (dout)
);

// File: tb/oddsel_rotator_tb_top.sv
`timescale 1ns/1ps
module oddsel_rotator_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] din = 8'h00;
    logic [2:0] sel = 3'b000;
    logic [7:0] dout;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;
    int exp_q[$];

    always #2.5 clk = ~clk;

    oddsel_rotator dut_i (.din(din), .sel(sel), .dout(dout));

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            fails = fails + 1;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    function automatic int model(input int d, input int s);
        int a;
        if ((s % 2) == 0) return 0;
        a = 2 * (s / 2) + 1;
        return ((d << a) | (d >> (8 - a))) & 255;
    endfunction

    function automatic string tag_of(input int s);
        case (s)
            1: return "R1";
            3: return "R2";
            5: return "R3";
            7: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int ones(input int v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += (v >> i) & 1;
        return n;
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1 check(dout == 8'h00, "R5 reset", dout, 0);

        // worked example word against each odd amount
        for (int s = 1; s < 8; s += 2) begin
            @(negedge clk);
            din = 8'hD0;
            sel = 3'(s);
            @(posedge clk); #1;
            check(int'(dout) == model(8'hD0, s), tag_of(s), dout, model(8'hD0, s));
        end
        check(model(8'hD0, 1) == 8'hA1 && model(8'hD0, 3) == 8'h86 &&
              model(8'hD0, 5) == 8'h1A && model(8'hD0, 7) == 8'h68,
              "R1 model", 0, 0);

        // exhaustive sweep, compared every clock through a queue
        for (int s = 0; s < 8; s++) begin
            for (int d = 0; d < 256; d++) begin
                @(negedge clk);
                din = 8'(d);
                sel = 3'(s);
                exp_q.push_back(model(d, s));
                @(posedge clk); #1;
                begin
                    int e;
                    e = exp_q.pop_front();
                    check(int'(dout) == e, tag_of(s), dout, e);
                    if ((s % 2) == 1)
                        check(ones(dout) == ones(d), "R6", ones(dout), ones(d));
                end
            end
        end

        // R7: output follows inputs between edges
        @(posedge clk); #0.5;
        din = 8'h81; sel = 3'b011;
        #0.5 check(dout == 8'h0C, "R7", dout, 8'h0C);
        sel = 3'b010;
        #0.5 check(dout == 8'h00, "R7", dout, 0);
        sel = 3'b111; din = 8'h01;
        #0.5 check(dout == 8'h80, "R7", dout, 8'h80);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule